// File: doc/BRIEF.md
# Variable-Window Oscillator Cycle Comparator

This block measures a local oscillator against a reference clock for a first-order digital frequency loop. It counts rising edges of the oscillator clock in a window opened by a clear strobe and closed by a sample strobe. Both strobes come from the loop controller in the reference domain. The controller makes each window 2^i reference cycles long, where i is its current sampling step, and it passes i with the sample strobe.

On a sample, the block freezes the edge count and splits it at bit i. The upper part, the count divided by 2^i, is compared with the target ratio N. The lower i bits are the residual error, and they are tested against a threshold. Because the split point moves with i, one comparison against N serves every window length. N never has to be scaled.

The counter runs in the oscillator domain. Both strobes cross into that domain as toggles through three-flop synchronizers. The frozen count comes back under a toggle acknowledge, so the reference side reads it only while it is stable. The result is a steering direction and a residual-in-range flag, marked by a one-cycle valid pulse.

Top module: `osc_window_cmp`

## Requirements
- R1: After a clear, the frozen count equals the number of oscillator rising edges that fall between the reference edge that accepted the clear and the reference edge that accepted the sample.
- R2: A clear restarts the count at zero. When a clear and a sample arrive in the same cycle, the sample freezes the old window and a new window opens at that same point.
- R3: The counter stops at all ones (2^(L+M)-1) instead of wrapping. A saturated count always yields direction -1.
- R4: For step i, the quotient is the frozen count shifted right by i, and the residual is the low i bits of the count.
- R5: `res_dir` encodes 2'b00 when the quotient equals N, 2'b01 (+1, oscillator slow) when the quotient is below N, and 2'b11 (-1, oscillator fast) when the quotient is above N. The code 2'b10 never appears.
- R6: `res_rem_ok` is 1 when the residual is at most `rem_thr`. At step 0 the residual is empty and the flag is always 1.
- R7: Each accepted sample gives exactly one `res_valid` pulse, one reference cycle wide. The result outputs hold their values between pulses.
- R8: A sample strobe that arrives while an earlier sample is still unanswered is ignored. It gives no pulse of its own, and its step, N and threshold do not change the pending result.
- R9: After reset, `res_valid`, `res_dir` and `res_rem_ok` are all 0.
- R10: A step index above M is treated as M.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ref_clk | input | 1 | Reference clock |
| osc_clk | input | 1 | Oscillator clock being measured |
| clr_req | input | 1 | Clear strobe that opens a new counting window (reference domain) |
| smp_req | input | 1 | Sample strobe that closes the window (reference domain) |
| smp_state | input | $clog2(M+1) | Sampling step i, captured with the sample strobe |
| mult_n | input | L | Target ratio N, captured with the sample strobe |
| rem_thr | input | M | Residual threshold, captured with the sample strobe |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| res_dir | output | 2 | Steering direction, coded as in R5 |
| res_rem_ok | output | 1 | Residual within threshold |

## Verification
The bench sweeps every N from 0 to 15 at every step index from 0 to 7, under eight oscillator speeds. It counts the oscillator edges itself, so the expected result is fixed by stimulus alone. This exposes a quotient split at the wrong bit or an off-by-one window: the direction would flip at the wrong N. It also exposes a wrapping counter, which would make a very fast oscillator look slow. Steps above M must reuse the top split, and a design that did not clamp them would compare an empty quotient. Separate cases send a second sample while the first is pending, and a clear in the same cycle as a sample. A design that re-armed on the second strobe would pulse twice or report the wrong step. A design that dropped the merged clear would stretch the next window.

// File: rtl/osc_window_cmp.sv
`timescale 1ns/1ps
module osc_window_cmp #(
  parameter int L = 4,
  parameter int M = 4
) (
  input  logic                       rst_n,
  input  logic                       ref_clk,
  input  logic                       osc_clk,
  input  logic                       clr_req,
  input  logic                       smp_req,
  input  logic [$clog2(M+1)-1:0]     smp_state,
  input  logic [L-1:0]               mult_n,
  input  logic [M-1:0]               rem_thr,
  output logic                       res_valid,
  output logic [1:0]                 res_dir,
  output logic                       res_rem_ok
);
  localparam int W  = L + M;
  localparam int SW = $clog2(M+1);
  localparam logic [W-1:0] ALL = '1;

  // reference-domain request side
  logic          clr_t, smp_t, pend;
  logic [SW-1:0] st_q;
  logic [L-1:0]  n_q;
  logic [M-1:0]  thr_q;
  logic [2:0]    ack_s;
  logic          ack_evt;

  // oscillator-domain counting side
  logic [2:0]    clr_s, smp_s;
  logic          clr_evt, smp_evt, ack_t;
  logic [W-1:0]  cnt, cnt_inc, snap;

  assign clr_evt = clr_s[2] ^ clr_s[1];
  assign smp_evt = smp_s[2] ^ smp_s[1];
  assign cnt_inc = (cnt == ALL) ? ALL : cnt + W'(1);

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_s <= '0;
      smp_s <= '0;
      cnt   <= '0;
      snap  <= '0;
      ack_t <= 1'b0;
    end else begin
      clr_s <= {clr_s[1:0], clr_t};
      smp_s <= {smp_s[1:0], smp_t};
      cnt   <= clr_evt ? '0 : cnt_inc;
      if (smp_evt) begin
        snap  <= cnt_inc;
        ack_t <= ~ack_t;
      end
    end
  end

  // decision datapath, read only while snap is frozen
  logic [SW-1:0] st_eff;
  logic [W-1:0]  quo, rem;
  logic [1:0]    dir_n;
  logic          ok_n;

  assign st_eff  = (st_q > SW'(M)) ? SW'(M) : st_q;
  assign quo     = snap >> st_eff;
  assign rem     = snap & ((W'(1) << st_eff) - W'(1));
  assign ack_evt = ack_s[2] ^ ack_s[1];
  assign ok_n    = (st_eff == '0) || (rem <= W'(thr_q));

  always_comb begin
    if (snap == ALL || quo > W'(n_q)) dir_n = 2'b11;
    else if (quo < W'(n_q))           dir_n = 2'b01;
    else                              dir_n = 2'b00;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_t      <= 1'b0;
      smp_t      <= 1'b0;
      pend       <= 1'b0;
      st_q       <= '0;
      n_q        <= '0;
      thr_q      <= '0;
      ack_s      <= '0;
      res_valid  <= 1'b0;
      res_dir    <= 2'b00;
      res_rem_ok <= 1'b0;
    end else begin
      ack_s     <= {ack_s[1:0], ack_t};
      res_valid <= 1'b0;
      if (clr_req) clr_t <= ~clr_t;
      if (smp_req && !pend) begin
        smp_t <= ~smp_t;
        pend  <= 1'b1;
        st_q  <= smp_state;
        n_q   <= mult_n;
        thr_q <= rem_thr;
      end
      if (ack_evt) begin
        pend       <= 1'b0;
        res_valid  <= 1'b1;
        res_dir    <= dir_n;
        res_rem_ok <= ok_n;
      end
    end
  end

  a_r1_count_step: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (!clr_evt && cnt != ALL) |=> cnt == $past(cnt) + W'(1));
  a_r2_clear_zero: assert property (@(posedge osc_clk) disable iff (!rst_n)
    clr_evt |=> cnt == '0);
  a_r3_hold_sat: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (!clr_evt && cnt == ALL) |=> cnt == ALL);
  a_r5_no_bad_code: assert property (@(posedge ref_clk) disable iff (!rst_n)
    res_valid |-> res_dir != 2'b10);
  a_r6_step0_pass: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (res_valid && st_q == '0) |-> res_rem_ok);
  a_r7_single_pulse: assert property (@(posedge ref_clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  a_r7_hold_dir: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !res_valid |=> (res_valid || $stable(res_dir)));
  a_r8_answer_clears: assert property (@(posedge ref_clk) disable iff (!rst_n)
    res_valid |-> !pend);
endmodule

// File: tb/sim_osc_window_cmp.sv
`timescale 1ns/1ps
module sim_osc_window_cmp;
  localparam int L = 4, M = 4, SW = 3, FULL = 255;

  logic rst_n = 0, ref_clk = 0, osc_clk = 0;
  logic clr_req = 0, smp_req = 0;
  logic [SW-1:0] smp_state = 0;
  logic [L-1:0]  mult_n = 0;
  logic [M-1:0]  rem_thr = 0;
  logic          res_valid, res_rem_ok;
  logic [1:0]    res_dir;

  int n_run = 0, n_fail = 0, osc_edges = 0, h_ps = 2000;
  bit done = 0;

  osc_window_cmp #(.L(L), .M(M)) u0 (.*);

  always #4 ref_clk = ~ref_clk;
  initial begin
    #0.301 osc_clk = 1;
    forever #(real'(h_ps) / 1000.0) osc_clk = ~osc_clk;
  end
  always @(posedge osc_clk) osc_edges++;

  task automatic chk(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model(int edges, int st, int n, int thr,
                                output int dir, output int ok);
    int c = edges > FULL ? FULL : edges;
    int s = st > M ? M : st;
    int q = c >> s;
    int r = c & ((1 << s) - 1);
    dir = (c == FULL || q > n) ? 3 : (q < n) ? 1 : 0;
    ok  = (s == 0 || r <= thr) ? 1 : 0;
  endfunction

  task automatic strobe(bit c, bit s, int st, int n, int thr, output int stamp);
    @(negedge ref_clk);
    clr_req = c; smp_req = s;
    smp_state = SW'(st); mult_n = L'(n); rem_thr = M'(thr);
    @(posedge ref_clk);
    stamp = osc_edges;
    @(negedge ref_clk);
    clr_req = 0; smp_req = 0;
  endtask

  task automatic get_res(string req, output bit got, output int dir, output int ok);
    got = 0; dir = 0; ok = 0;
    for (int k = 0; k < 40 && !got; k++) begin
      if (res_valid) begin
        got = 1; dir = res_dir; ok = res_rem_ok;
      end else @(negedge ref_clk);
    end
    chk(got, req, got, 1);
    if (got) begin
      @(negedge ref_clk);
      chk(!res_valid, "R7 pulse width", res_valid, 0);
      chk(res_dir == 2'(dir), "R7 hold", res_dir, dir);
    end
  endtask

  task automatic window(int st, int n, int thr, int len);
    int ec, es, ed, eo, dir, ok;
    bit got;
    strobe(1, 0, 0, 0, 0, ec);
    repeat (len - 1) @(negedge ref_clk);
    strobe(0, 1, st, n, thr, es);
    model(es - ec, st, n, thr, ed, eo);
    get_res("R1 valid", got, dir, ok);
    if (st > M)           chk(dir == ed, "R10 dir", dir, ed);
    else if (es - ec > FULL) chk(dir == ed, "R3 dir", dir, ed);
    else                  chk(dir == ed, "R5 R4 R1 dir", dir, ed);
    chk(ok == eo, "R6 rem_ok", ok, eo);
  endtask

  initial begin
    int halves[8] = '{4000, 2000, 1334, 1000, 666, 400, 290, 200};
    int ec, es, es2, ed, eo, dir, ok;
    bit got;
    repeat (3) @(negedge ref_clk);
    chk(res_valid == 0, "R9 valid", res_valid, 0);
    chk(res_dir == 0, "R9 dir", res_dir, 0);
    chk(res_rem_ok == 0, "R9 rem_ok", res_rem_ok, 0);
    rst_n = 1;
    repeat (3) @(negedge ref_clk);

    for (int hi = 0; hi < 8; hi++) begin
      h_ps = halves[hi];
      for (int st = 0; st < 8; st++)
        for (int n = 0; n < 16; n++)
          window(st, n, (n * 5 + st) % 16, 1 << (st > 5 ? 5 : st));
    end

    // R8: a second strobe while one is pending is ignored
    h_ps = 1000;
    strobe(1, 0, 0, 0, 0, ec);
    repeat (7) @(negedge ref_clk);
    strobe(0, 1, 3, 4, 2, es);
    strobe(0, 1, 0, 0, 0, es2);
    model(es - ec, 3, 4, 2, ed, eo);
    get_res("R8 valid", got, dir, ok);
    chk(dir == ed, "R8 dir", dir, ed);
    chk(ok == eo, "R8 rem_ok", ok, eo);
    for (int k = 0; k < 30; k++) begin
      @(negedge ref_clk);
      chk(!res_valid, "R8 extra pulse", res_valid, 0);
    end

    // R2: clear and sample in one cycle
    h_ps = 666;
    strobe(1, 0, 0, 0, 0, ec);
    repeat (3) @(negedge ref_clk);
    strobe(1, 1, 2, 6, 1, es);
    model(es - ec, 2, 6, 1, ed, eo);
    get_res("R2 first", got, dir, ok);
    chk(dir == ed, "R2 first dir", dir, ed);
    for (int n = 0; n < 16; n++) begin
      strobe(0, 1, 4, n, 3, es2);
      model(es2 - es, 4, n, 3, ed, eo);
      get_res("R2 merged valid", got, dir, ok);
      chk(dir == ed, "R2 merged dir", dir, ed);
      chk(ok == eo, "R2 merged rem_ok", ok, eo);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge ref_clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule